// File: doc/BRIEF.md
# SPI Slave with Buffered Transmit

This block is the receiving end of a four-wire serial link. An external master supplies the serial clock, the active-low select and the master-to-slave data line. Data moves in 8-bit frames, most significant bit first. The same shift register sends the slave's byte out while it takes the master's byte in. A CPU-side write port fills a transmit holding register, which is copied into the shift register when a byte begins. Each finished incoming byte is placed in a receive register and raises a full flag. A byte that finishes while the earlier one is still unread raises an overrun flag instead of replacing it.

The two mode inputs select the idle level of the serial clock and the phase of data relative to the clock. In phase-0 operation the falling edge of select starts the byte, and the first bit appears on the output before any clock edge. Select must then be released and asserted again for the next byte. In phase-1 operation the first clock edge after select goes low starts the byte, and select may stay low across several bytes. All serial inputs pass through two synchronising flip-flops into the system clock domain, so the system clock must run at least four times faster than the serial clock. The slave output and its driver enable are brought out separately for a tri-state pad. The enable follows the synchronised select, so it is high only while the slave is selected.

Top module: `spi_slv_top`

## Requirements
- R1: After reset, tx_empty is 1, rx_full is 0, overrun is 0 and miso_oe is 0.
- R2: miso_oe is 1 only while ss_n (after synchronisation) is low, and 0 while ss_n is high.
- R3: A frame is 8 bits, most significant bit first in both directions. The byte placed in rx_data equals the 8 bits sampled from mosi, first bit sampled as bit 7.
- R4: With cpol=0 the clock idles low and the leading edge is rising. With cpol=1 it idles high and the leading edge is falling. Transfers work the same in both cases.
- R5: With cpha=0, the falling edge of ss_n copies the holding register into the shift register and puts bit 7 on miso before the first clock edge. mosi is sampled on leading edges and miso changes on trailing edges.
- R6: With cpha=0, once 8 bits have been sampled, further clock edges have no effect until ss_n goes high and low again. No second byte is received.
- R7: With cpha=1, the first leading edge while ss_n is low loads the shift register and drives bit 7. Data is sampled on trailing edges. Consecutive bytes may be sent with ss_n held low.
- R8: A CPU write after a byte has started does not change that byte. The value is kept and sent in the next byte.
- R9: tx_empty is set when the holding register is copied into the shift register and cleared by a write. When a write and a copy fall in the same cycle, the old value is sent and tx_empty ends up 0.
- R10: A completed byte sets rx_full with the byte in rx_data. A one-cycle rd_ack pulse clears rx_full and overrun.
- R11: If a byte completes while rx_full is 1 and rd_ack is 0, overrun is set and rx_data keeps the earlier byte.
- R12: If ss_n rises before 8 bits have been sampled, the partial byte is dropped and the receive flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase: 0 = select edge starts the byte, 1 = first clock edge starts it |
| sck | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Driver enable for the miso pad |
| wr_en | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | 8 | Byte to transmit |
| rd_ack | input | 1 | Acknowledge that rx_data was taken |
| rx_data | output | 8 | Last accepted received byte |
| rx_full | output | 1 | rx_data holds an unread byte |
| tx_empty | output | 1 | The holding register has been copied out |
| overrun | output | 1 | A byte completed while rx_full was set |

## Verification
Two events can fall in the same system cycle: a CPU write to the holding register, and the copy from that register into the shift register that a detected select fall triggers. The bench counts the two synchroniser stages and the edge-detect register. It then raises wr_en for exactly the cycle in which the copy happens. It expects the byte on miso to be the older value, tx_empty to read 0 afterwards, and the newer value to go out in the following byte. Random writes, reads and mode changes around ordinary transfers exercise the neighbouring timings as well.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACTIVE = 2'd1,
      ST_DONE   = 2'd2
   } spi_state_t;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
   parameter int          N       = 3,
   parameter int          STAGES  = 2,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_slv_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < N; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
         else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/spi_slv_engine.sv
module spi_slv_engine
   import spi_slv_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cpha,
   input  logic         lead,
   input  logic         trail,
   input  logic         ss_low,
   input  logic         ss_fall,
   input  logic         mosi_s,
   input  logic [W-1:0] hold,
   output logic         load,
   output logic         miso_bit,
   output logic         rx_valid,
   output logic [W-1:0] rx_byte
);
   localparam int CNT_W = $clog2(W + 1);

   spi_state_t       state;
   logic [W-1:0]     sh;
   logic [CNT_W-1:0] cnt;
   logic             samp;
   logic             samp_edge, shift_edge, last_bit;

   assign samp_edge  = cpha ? trail : lead;
   assign shift_edge = cpha ? lead  : trail;
   assign last_bit   = (cnt == CNT_W'(W - 1));

   // phase 0 starts on the select fall, phase 1 on the first leading edge
   assign load = ss_low && ((!cpha && ss_fall) ||
                            (cpha && (state == ST_IDLE) && lead));

   assign rx_valid = ss_low && (state == ST_ACTIVE) && samp_edge && last_bit;
   assign rx_byte  = {sh[W-2:0], mosi_s};
   assign miso_bit = sh[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         sh    <= '0;
         cnt   <= '0;
         samp  <= 1'b0;
      end else if (!ss_low) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else if (load) begin
         sh    <= hold;
         state <= ST_ACTIVE;
         cnt   <= '0;
      end else if (state == ST_ACTIVE) begin
         if (samp_edge) begin
            samp <= mosi_s;
            cnt  <= cnt + 1'b1;
            if (last_bit) state <= cpha ? ST_IDLE : ST_DONE;
         end else if (shift_edge) begin
            sh <= {sh[W-2:0], samp};
         end
      end
   end

   // R6
   done_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DONE) |=> $stable(sh));

   // R3
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(W));
endmodule

// File: rtl/spi_slv_rxbuf.sv
module spi_slv_rxbuf #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rx_valid,
   input  logic [W-1:0] rx_byte,
   input  logic         rd_ack,
   output logic [W-1:0] rx_data,
   output logic         rx_full,
   output logic         overrun
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data <= '0;
         rx_full <= 1'b0;
         overrun <= 1'b0;
      end else if (rx_valid && (!rx_full || rd_ack)) begin
         rx_data <= rx_byte;
         rx_full <= 1'b1;
         if (rd_ack) overrun <= 1'b0;
      end else if (rx_valid) begin
         overrun <= 1'b1;
      end else if (rd_ack) begin
         rx_full <= 1'b0;
         overrun <= 1'b0;
      end
   end

   // R10
   full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_full) |-> $past(rd_ack));

   // R11
   ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(rx_full));

   // R11
   keep_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !rd_ack) |=> $stable(rx_data));
endmodule

// File: rtl/spi_slv_top.sv
module spi_slv_top #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              sck,
   input  logic              ss_n,
   input  logic              mosi,
   output logic              miso_o,
   output logic              miso_oe,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_ack,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              tx_empty,
   output logic              overrun
);
   if (DATA_W < 2) begin : g_bad_width
      $error("spi_slv_top: DATA_W must be at least 2");
   end

   logic [2:0]        pins_s;
   logic              sck_s, ss_s, mosi_s;
   logic              sck_n, sck_nd, ss_d;
   logic              lead, trail, ss_low, ss_fall;
   logic              load, rx_valid;
   logic [DATA_W-1:0] hold, rx_byte;

   spi_slv_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({mosi, ss_n, sck}),
      .q     (pins_s)
   );
   assign sck_s  = pins_s[0];
   assign ss_s   = pins_s[1];
   assign mosi_s = pins_s[2];

   // normalise so that the leading edge is always a rise
   assign sck_n = sck_s ^ cpol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_nd <= 1'b0;
         ss_d   <= 1'b1;
      end else begin
         sck_nd <= sck_n;
         ss_d   <= ss_s;
      end
   end

   assign lead    = sck_n & ~sck_nd;
   assign trail   = ~sck_n & sck_nd;
   assign ss_low  = ~ss_s;
   assign ss_fall = ~ss_s & ss_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold     <= '0;
         tx_empty <= 1'b1;
      end else if (wr_en) begin
         hold     <= wr_data;
         tx_empty <= 1'b0;
      end else if (load) begin
         tx_empty <= 1'b1;
      end
   end

   spi_slv_engine #(.W(DATA_W)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpha     (cpha),
      .lead     (lead),
      .trail    (trail),
      .ss_low   (ss_low),
      .ss_fall  (ss_fall),
      .mosi_s   (mosi_s),
      .hold     (hold),
      .load     (load),
      .miso_bit (miso_o),
      .rx_valid (rx_valid),
      .rx_byte  (rx_byte)
   );

   spi_slv_rxbuf #(.W(DATA_W)) u_rxbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .rx_byte  (rx_byte),
      .rd_ack   (rd_ack),
      .rx_data  (rx_data),
      .rx_full  (rx_full),
      .overrun  (overrun)
   );

   assign miso_oe = ss_low;

   // R9
   empty_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_empty) |-> $past(load));

   // R9
   write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !tx_empty);
endmodule

// File: tb/spi_slv_top_bench.sv
`timescale 1ns/1ps
module spi_slv_top_bench;
   localparam int H = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpol_i = 1'b0, cpha_i = 1'b0;
   logic       sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
   logic       miso_o, miso_oe;
   logic       wr_en = 1'b0, rd_ack = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rx_data;
   logic       rx_full, tx_empty, overrun;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   logic [7:0] m_hold = '0, m_data = '0;
   logic       m_empty = 1'b1, m_full = 1'b0, m_ovr = 1'b0;

   always #2 clk = ~clk;

   spi_slv_top u_spi_slv_top (
      .clk(clk), .rst_n(rst_n), .cpol(cpol_i), .cpha(cpha_i),
      .sck(sck), .ss_n(ss_n), .mosi(mosi),
      .miso_o(miso_o), .miso_oe(miso_oe),
      .wr_en(wr_en), .wr_data(wr_data), .rd_ack(rd_ack),
      .rx_data(rx_data), .rx_full(rx_full), .tx_empty(tx_empty), .overrun(overrun)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [7:0] start_byte();
      m_empty = 1'b1;
      return m_hold;
   endfunction

   function automatic void model_rx(input logic [7:0] b);
      if (!m_full) begin m_data = b; m_full = 1'b1; end
      else m_ovr = 1'b1;
   endfunction

   task automatic cpu_wr(input logic [7:0] v);
      @(negedge clk); wr_en = 1'b1; wr_data = v;
      @(negedge clk); wr_en = 1'b0;
      m_hold = v; m_empty = 1'b0;
   endtask

   task automatic cpu_rd();
      @(negedge clk); rd_ack = 1'b1;
      @(negedge clk); rd_ack = 1'b0;
      m_full = 1'b0; m_ovr = 1'b0;
   endtask

   task automatic set_mode(input logic pol, input logic pha);
      @(negedge clk); sck = pol; cpol_i = pol; cpha_i = pha;
      wait_n(H);
   endtask

   task automatic sel_low();
      @(negedge clk); ss_n = 1'b0; wait_n(H);
   endtask

   task automatic sel_high();
      @(negedge clk); ss_n = 1'b1; wait_n(H);
   endtask

   task automatic xfer(input logic [7:0] m, input int nbits, output logic [7:0] got);
      got = '0;
      if (!cpha_i) begin
         mosi = m[7]; wait_n(H);
         for (int i = 0; i < nbits; i++) begin
            got[7-i] = miso_o;
            sck = ~cpol_i; wait_n(H);
            sck = cpol_i;
            if (i < 7) mosi = m[6-i];
            wait_n(H);
         end
      end else begin
         for (int i = 0; i < nbits; i++) begin
            sck = ~cpol_i; mosi = m[7-i]; wait_n(H);
            got[7-i] = miso_o;
            sck = cpol_i; wait_n(H);
         end
      end
   endtask

   task automatic check_flags(input string req);
      chk(rx_full == m_full, {req, " rx_full"}, rx_full, m_full);
      chk(overrun == m_ovr, {req, " overrun"}, overrun, m_ovr);
      chk(rx_data == m_data, {req, " rx_data"}, rx_data, m_data);
      chk(tx_empty == m_empty, {req, " tx_empty"}, tx_empty, m_empty);
   endtask

   task automatic one_byte(input logic [7:0] m, input string req);
      logic [7:0] got, exp;
      sel_low();
      if (!cpha_i) exp = start_byte();
      else exp = m_hold;
      chk(miso_oe == 1'b1, "R2 oe while selected", miso_oe, 1);
      if (cpha_i) exp = start_byte();
      xfer(m, 8, got);
      model_rx(m);
      chk(got == exp, {req, " miso byte"}, got, exp);
      sel_high();
      chk(miso_oe == 1'b0, "R2 oe released", miso_oe, 0);
      check_flags(req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] got, exp, old_b;
      void'($urandom(32'h5EED_0042));
      wait_n(4);
      rst_n = 1'b1;
      wait_n(4);
      // R1
      chk(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);
      chk(rx_full == 1'b0, "R1 rx_full", rx_full, 0);
      chk(overrun == 1'b0, "R1 overrun", overrun, 0);
      chk(miso_oe == 1'b0, "R1 miso_oe", miso_oe, 0);

      // R3 R5: phase 0, polarity 0
      set_mode(1'b0, 1'b0);
      cpu_wr(8'hA5);
      one_byte(8'h3C, "R3 R5 cpol0 cpha0");

      // R4: polarity 1
      cpu_rd();
      set_mode(1'b1, 1'b0);
      cpu_wr(8'h81);
      one_byte(8'h7E, "R4 cpol1 cpha0");

      // R11 then R10
      one_byte(8'hC3, "R11 overrun");
      chk(rx_data == 8'h7E, "R11 old byte kept", rx_data, 8'h7E);
      cpu_rd();
      check_flags("R10 read clears");

      // R6: no second byte without select toggle
      set_mode(1'b0, 1'b0);
      cpu_wr(8'h5A);
      sel_low();
      exp = start_byte();
      xfer(8'h11, 8, got);
      model_rx(8'h11);
      chk(got == exp, "R6 first byte", got, exp);
      cpu_rd();
      xfer(8'h22, 8, got);
      chk(rx_full == 1'b0, "R6 no second byte", rx_full, 0);
      sel_high();
      check_flags("R6");

      // R7: phase 1, two bytes under one select
      set_mode(1'b0, 1'b1);
      cpu_wr(8'hE7);
      sel_low();
      exp = start_byte();
      xfer(8'h96, 8, got);
      model_rx(8'h96);
      chk(got == exp, "R7 byte 1", got, exp);
      cpu_rd();
      cpu_wr(8'h18);
      exp = start_byte();
      xfer(8'h69, 8, got);
      model_rx(8'h69);
      chk(got == exp, "R7 byte 2", got, exp);
      sel_high();
      check_flags("R7");
      cpu_rd();

      // R8: write during a byte
      set_mode(1'b1, 1'b1);
      cpu_wr(8'h0F);
      sel_low();
      exp = start_byte();
      fork
         xfer(8'hF0, 8, got);
         begin wait_n(40); cpu_wr(8'hB4); end
      join
      model_rx(8'hF0);
      chk(got == exp, "R8 current byte unchanged", got, exp);
      sel_high();
      check_flags("R8");
      cpu_rd();
      one_byte(8'h44, "R8 next byte sends new");

      // R9: write in the same cycle as the copy
      cpu_rd();
      set_mode(1'b0, 1'b0);
      cpu_wr(8'hC8);
      @(negedge clk); ss_n = 1'b0;
      old_b = start_byte();
      @(posedge clk); @(posedge clk);
      @(negedge clk); wr_en = 1'b1; wr_data = 8'h37;
      @(negedge clk); wr_en = 1'b0;
      m_hold = 8'h37; m_empty = 1'b0;
      wait_n(H);
      xfer(8'h55, 8, got);
      model_rx(8'h55);
      chk(got == old_b, "R9 collision sends old", got, old_b);
      sel_high();
      check_flags("R9 collision");
      cpu_rd();
      one_byte(8'hAA, "R9 newer value next");

      // R12: abort mid byte
      cpu_rd();
      sel_low();
      exp = start_byte();
      xfer(8'hFF, 3, got);
      sel_high();
      check_flags("R12 abort");

      // random mix
      for (int k = 0; k < 40; k++) begin
         logic [7:0] mb;
         set_mode(1'($urandom % 2), 1'($urandom % 2));
         if ($urandom % 2) cpu_wr(8'($urandom));
         if ($urandom % 3 != 0) cpu_rd();
         mb = 8'($urandom);
         one_byte(mb, "R3 R4 R5 R7 R10 R11 random");
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule